// File: doc/BRIEF.md
# Multi-Speed DMA Cycle Timing Sequencer

This block times the repeated transfer cycles of a four-channel legacy-bus DMA controller running in block or demand mode. Each channel carries a two-bit timing mode that sets how many clocks one transfer cycle lasts. During each cycle the block drives the active-low read and write command strobes on the memory side and the I/O side, holds the channel's active-low acknowledge, and pulses a done flag on the last clock of the cycle. Address and count generation are handled elsewhere and are driven by the done pulse.

Incoming requests are conditioned per channel before a fixed-priority arbiter sees them. On a channel running compatible timing, a hardware request must stay high for a minimum number of clocks before it counts. Faster timing modes and software request bits skip this wait. Once a channel is granted, it keeps the acknowledge for as long as its request persists. When the request is withdrawn, the current cycle finishes, the channel is released and its latency count starts again.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, all four acknowledges and all four command strobes are high (inactive) and done is low.
- R2: A cycle lasts 8, 6, 5 or 3 clocks for mode codes 00, 01, 10 and 11, taken from bits [2c+1:2c] of the mode input for channel c. In a continuous transfer, done pulses are exactly that many clocks apart.
- R3: When a channel's fast-memory bit is 0, mode codes 01, 10 and 11 fall back to the 8-clock compatible cycle, and the channel also takes the compatible request latency.
- R4: On a channel whose effective mode is compatible, a hardware request held high starting before rising edge 1 produces its acknowledge after rising edge 9. A request that drops earlier is never granted.
- R5: A software request bit, or a hardware request on a channel with a non-compatible effective mode, reaches the arbiter at once, so the acknowledge follows after the first rising edge.
- R6: At most one acknowledge is low at a time. When several channels request together, the lowest-numbered channel wins.
- R7: Within a cycle of length L with phases 1..L, the read strobe is active in phases 1..L-1, the write strobe in phases 2..L-1, and in phase L every strobe is inactive while done is high. Direction bit 0 means memory-to-I/O (the memory read and I/O write strobes are used). Direction bit 1 means I/O-to-memory (the I/O read and memory write strobes are used).
- R8: A granted channel keeps its acknowledge from cycle to cycle while its request stays present, even if a higher-priority channel starts requesting.
- R9: When the granted channel's request is absent in the done phase, the acknowledge goes high on the next edge. A compatible hardware request must then wait the full latency again.
- R10: Mode, fast-memory bit and direction are sampled at the start of each cycle and hold for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_i | input | 4 | Hardware request per channel, active high |
| sw_req_i | input | 4 | Software request per channel, active high |
| tmode_i | input | 8 | Two-bit timing mode per channel |
| fast_mem_i | input | 4 | Per channel: memory side is fast system memory |
| dir_i | input | 4 | Per channel: 1 = I/O-to-memory, 0 = memory-to-I/O |
| dack_n_o | output | 4 | Active-low acknowledge per channel |
| ior_n_o | output | 1 | Active-low I/O read strobe |
| iow_n_o | output | 1 | Active-low I/O write strobe |
| memr_n_o | output | 1 | Active-low memory read strobe |
| memw_n_o | output | 1 | Active-low memory write strobe |
| done_o | output | 1 | One-clock pulse on the last phase of each cycle |

## Verification
The assertions check on every cycle that at most one acknowledge is low and that the arbiter's grant is one-hot. They also check that no write strobe is active without a read strobe, that the done phase has every strobe idle, that the acknowledge changes only when the sequencer is idle or in a done phase, and that a compatible hardware request reaches the arbiter only after its line was already high. The exact cycle lengths, the fallback to compatible timing, the nine-edge latency, the priority order and the restart of latency after a release depend on counted clocks. These are shown only by the bench's directed scenarios and by its reference model running under random requests.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    TM_COMPAT = 2'b00,
    TM_A      = 2'b01,
    TM_B      = 2'b10,
    TM_F      = 2'b11
  } tmode_e;

  // Faster modes are only legal toward fast system memory.
  function automatic tmode_e eff_mode(input logic [1:0] code, input logic fast);
    return fast ? tmode_e'(code) : TM_COMPAT;
  endfunction

endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond #(
  parameter int unsigned REQ_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic sw_req,
  input  logic compat,
  input  logic clr,
  output logic req
);
  localparam int unsigned CW = $clog2(REQ_LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hw_ok;

  always_comb begin
    if (!dreq || clr)               cnt_d = '0;
    else if (cnt_q != CW'(REQ_LAT)) cnt_d = cnt_q + CW'(1);
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hw_ok = compat ? (dreq && (cnt_q == CW'(REQ_LAT))) : dreq;
  assign req   = hw_ok | sw_req;

  // R4: a held-back hardware request appears only after its line was high
  p_lat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req) && !sw_req && compat) |-> $past(dreq));

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (req[c]) gnt = NUM_CH'(1) << c;
    end
  end

  // R6: single grant, and a grant whenever anything requests
  always_comb begin
    p_arb_onehot_r6: assert ($onehot0(gnt));
    p_arb_live_r6:   assert ((req == '0) || (gnt != '0));
  end

endmodule

// File: rtl/dma_cycle_fsm.sv
module dma_cycle_fsm
  import dma_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned LEN_COMPAT = 8,
  parameter int unsigned LEN_A      = 6,
  parameter int unsigned LEN_B      = 5,
  parameter int unsigned LEN_F      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     req,
  input  logic [NUM_CH-1:0]     gnt,
  input  logic [2*NUM_CH-1:0]   tmode,
  input  logic [NUM_CH-1:0]     fast_mem,
  input  logic [NUM_CH-1:0]     dir,
  output logic [NUM_CH-1:0]     dack_n,
  output logic [NUM_CH-1:0]     rel,
  output logic                  ior_n,
  output logic                  iow_n,
  output logic                  memr_n,
  output logic                  memw_n,
  output logic                  done
);
  localparam int unsigned LMAX =
    (LEN_COMPAT > LEN_A) ? ((LEN_COMPAT > LEN_B) ? LEN_COMPAT : LEN_B) : LEN_A;
  localparam int unsigned LW = $clog2(LMAX + 1);

  logic              act_q, act_d;
  logic [NUM_CH-1:0] ch_q, ch_d;
  logic [LW-1:0]     ph_q, ph_d, len_q, len_d;
  logic              dir_q, dir_d;
  logic [NUM_CH-1:0] sel;
  logic [1:0]        sel_mode;
  logic              sel_fast, sel_dir, cont, rd, wr;
  logic [LW-1:0]     sel_len;

  // Per-cycle parameters of the channel about to start a cycle.
  always_comb begin
    sel      = act_q ? ch_q : gnt;
    sel_mode = '0;
    sel_fast = 1'b0;
    sel_dir  = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel[c]) begin
        sel_mode = tmode[2*c +: 2];
        sel_fast = fast_mem[c];
        sel_dir  = dir[c];
      end
    end
    case (eff_mode(sel_mode, sel_fast))
      TM_A:    sel_len = LW'(LEN_A);
      TM_B:    sel_len = LW'(LEN_B);
      TM_F:    sel_len = LW'(LEN_F);
      default: sel_len = LW'(LEN_COMPAT);
    endcase
  end

  assign done = act_q && (ph_q == len_q);
  assign cont = |(req & ch_q);

  always_comb begin
    act_d = act_q;
    ch_d  = ch_q;
    ph_d  = ph_q;
    len_d = len_q;
    dir_d = dir_q;
    rel   = '0;
    if (!act_q) begin
      if (|gnt) begin
        act_d = 1'b1;
        ch_d  = gnt;
        ph_d  = LW'(1);
        len_d = sel_len;
        dir_d = sel_dir;
      end
    end else if (done) begin
      if (cont) begin
        ph_d  = LW'(1);
        len_d = sel_len;
        dir_d = sel_dir;
      end else begin
        act_d = 1'b0;
        ch_d  = '0;
        rel   = ch_q;
      end
    end else begin
      ph_d = ph_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ch_q  <= '0;
      ph_q  <= '0;
      len_q <= '0;
      dir_q <= 1'b0;
    end else begin
      act_q <= act_d;
      ch_q  <= ch_d;
      ph_q  <= ph_d;
      len_q <= len_d;
      dir_q <= dir_d;
    end
  end

  assign rd     = act_q && (ph_q < len_q);
  assign wr     = act_q && (ph_q >= LW'(2)) && (ph_q < len_q);
  assign memr_n = ~(rd && !dir_q);
  assign ior_n  = ~(rd &&  dir_q);
  assign iow_n  = ~(wr && !dir_q);
  assign memw_n = ~(wr &&  dir_q);
  assign dack_n = ~ch_q;

  p_one_dack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));
  p_wr_in_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iow_n || !memw_n) |-> (!ior_n || !memr_n));
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ior_n && iow_n && memr_n && memw_n && !(&dack_n)));
  p_dack_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dack_n) |-> ($past(done) || $past(&dack_n)));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&dack_n) |-> $past(done));

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned REQ_LAT    = 8,
  parameter int unsigned LEN_COMPAT = 8,
  parameter int unsigned LEN_A      = 6,
  parameter int unsigned LEN_B      = 5,
  parameter int unsigned LEN_F      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   dreq_i,
  input  logic [NUM_CH-1:0]   sw_req_i,
  input  logic [2*NUM_CH-1:0] tmode_i,
  input  logic [NUM_CH-1:0]   fast_mem_i,
  input  logic [NUM_CH-1:0]   dir_i,
  output logic [NUM_CH-1:0]   dack_n_o,
  output logic                ior_n_o,
  output logic                iow_n_o,
  output logic                memr_n_o,
  output logic                memw_n_o,
  output logic                done_o
);
  logic [NUM_CH-1:0] req, gnt, rel, compat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign compat[c] = (eff_mode(tmode_i[2*c +: 2], fast_mem_i[c]) == TM_COMPAT);

    dma_req_cond #(.REQ_LAT(REQ_LAT)) i_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .dreq   (dreq_i[c]),
      .sw_req (sw_req_i[c]),
      .compat (compat[c]),
      .clr    (rel[c]),
      .req    (req[c])
    );
  end

  dma_arb #(.NUM_CH(NUM_CH)) i_arb (
    .req (req),
    .gnt (gnt)
  );

  dma_cycle_fsm #(
    .NUM_CH(NUM_CH), .LEN_COMPAT(LEN_COMPAT),
    .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_F(LEN_F)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .gnt      (gnt),
    .tmode    (tmode_i),
    .fast_mem (fast_mem_i),
    .dir      (dir_i),
    .dack_n   (dack_n_o),
    .rel      (rel),
    .ior_n    (ior_n_o),
    .iow_n    (iow_n_o),
    .memr_n   (memr_n_o),
    .memw_n   (memw_n_o),
    .done     (done_o)
  );

endmodule

// File: tb/test_dma_cycle_seq.sv
module test_dma_cycle_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dreq, sw_req, fast_mem, dir;
  logic [7:0] tmode;
  logic [3:0] dack_n;
  logic       ior_n, iow_n, memr_n, memw_n, done;

  always #5 clk = ~clk;

  dma_cycle_seq i_dma_cycle_seq (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .sw_req_i(sw_req),
    .tmode_i(tmode), .fast_mem_i(fast_mem), .dir_i(dir),
    .dack_n_o(dack_n), .ior_n_o(ior_n), .iow_n_o(iow_n),
    .memr_n_o(memr_n), .memw_n_o(memw_n), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  bit model_cmp = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected cycle length from the mode code and fast-memory bit (R2, R3).
  function automatic int exp_len(input logic [1:0] m, input logic f);
    if (!f) return 8;
    case (m)
      2'b01:   return 6;
      2'b10:   return 5;
      2'b11:   return 3;
      default: return 8;
    endcase
  endfunction

  function automatic bit exp_compat(input logic [1:0] m, input logic f);
    return exp_len(m, f) == 8;
  endfunction

  // Reference model, stepped on each rising edge.
  int m_cnt[4];
  int m_g, m_ph, m_len;
  bit m_dir;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) m_cnt[c] = 0;
      m_g = -1; m_ph = 0; m_len = 0; m_dir = 0;
    end else begin
      bit creq[4];
      int rel;
      rel = -1;
      for (int c = 0; c < 4; c++)
        creq[c] = (exp_compat(tmode[2*c +: 2], fast_mem[c]) ?
                   (dreq[c] && m_cnt[c] == 8) : dreq[c]) || sw_req[c];
      if (m_g < 0) begin
        for (int c = 3; c >= 0; c--)
          if (creq[c]) m_g = c;
        if (m_g >= 0) begin
          m_ph = 1;
          m_len = exp_len(tmode[2*m_g +: 2], fast_mem[m_g]);
          m_dir = dir[m_g];
        end
      end else if (m_ph == m_len) begin
        if (creq[m_g]) begin
          m_ph = 1;
          m_len = exp_len(tmode[2*m_g +: 2], fast_mem[m_g]);
          m_dir = dir[m_g];
        end else begin
          rel = m_g;
          m_g = -1;
        end
      end else begin
        m_ph++;
      end
      for (int c = 0; c < 4; c++)
        if (!dreq[c] || c == rel) m_cnt[c] = 0;
        else if (m_cnt[c] < 8)    m_cnt[c]++;
    end
  end

  // R10 together with R6/R7: every output against the model, sampled mid-cycle.
  always @(negedge clk) begin
    if (model_cmp) begin
      bit act, rd, wr, dn;
      logic [3:0] e_dack;
      logic [3:0] got, exp;
      act = (m_g >= 0);
      rd = act && m_ph < m_len;
      wr = act && m_ph >= 2 && m_ph < m_len;
      dn = act && m_ph == m_len;
      e_dack = act ? ~(4'b1 << m_g) : 4'hF;
      got = {~memr_n, ~ior_n, ~memw_n, ~iow_n};
      exp = {rd && !m_dir, rd && m_dir, wr && m_dir, wr && !m_dir};
      chk(dack_n == e_dack, "R10 dack", dack_n, e_dack);
      chk(got == exp, "R10 strobes", got, exp);
      chk(done == dn, "R10 done", done, dn);
    end
  end

  task automatic idle_inputs();
    dreq = '0; sw_req = '0; tmode = '0; fast_mem = '0; dir = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      if (dack_n == 4'hF) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // Raise a request on ch, count edges to grant, then measure the done period.
  task automatic measure(input int ch, input logic [1:0] m, input logic f, input bit sw,
                         output int lat, output int per);
    tmode[2*ch +: 2] = m; fast_mem[ch] = f; dir[ch] = 1'b0;
    if (sw) sw_req[ch] = 1'b1; else dreq[ch] = 1'b1;
    lat = 99;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (!dack_n[ch]) begin lat = n; break; end
    end
    while (!done) @(negedge clk);
    per = 0;
    do begin @(negedge clk); per++; end while (!done && per < 20);
    sw_req[ch] = 1'b0; dreq[ch] = 1'b0;
    wait_idle();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, per, n;
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dack_n == 4'hF, "R1 dack in reset", dack_n, 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dack_n == 4'hF && done == 1'b0, "R1 dack after reset", dack_n, 15);
    chk({ior_n, iow_n, memr_n, memw_n} == 4'hF, "R1 strobes", {ior_n, iow_n, memr_n, memw_n}, 15);

    // R4 latency and R7 strobe shape on a compatible channel, memory-to-I/O.
    dreq[2] = 1'b1;
    lat = 99;
    for (n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (!dack_n[2]) begin lat = n; break; end
    end
    chk(lat == 9, "R4 compat latency", lat, 9);
    chk(!memr_n && iow_n && ior_n && memw_n, "R7 phase1", {memr_n, iow_n}, 1);
    @(negedge clk);
    chk(!memr_n && !iow_n, "R7 phase2", {memr_n, iow_n}, 0);
    repeat (6) @(negedge clk);
    chk(done && memr_n && iow_n, "R7 last phase", {done, memr_n, iow_n}, 7);
    @(negedge clk);
    // R9: drop request in phase 1, expect done at 7 more edges and release at 8
    dreq[2] = 1'b0;
    repeat (7) @(negedge clk);
    chk(done == 1'b1 && dack_n[2] == 1'b0, "R9 cycle finishes", done, 1);
    @(negedge clk);
    chk(dack_n == 4'hF, "R9 released", dack_n, 15);
    dreq[2] = 1'b1;
    lat = 99;
    for (n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (!dack_n[2]) begin lat = n; break; end
    end
    chk(lat == 9, "R9 latency restarts", lat, 9);
    dreq[2] = 1'b0;
    wait_idle();

    // R4: a short hardware pulse on a compatible channel is never granted.
    dreq[1] = 1'b1;
    repeat (5) @(negedge clk);
    dreq[1] = 1'b0;
    repeat (12) @(negedge clk);
    chk(dack_n == 4'hF, "R4 short pulse ignored", dack_n, 15);

    // R5 software bypass on a compatible channel.
    measure(3, 2'b00, 1'b0, 1'b1, lat, per);
    chk(lat == 1, "R5 sw bypass", lat, 1);
    chk(per == 8, "R2 compat period", per, 8);
    // R2 and R5 for fast modes with hardware requests.
    measure(1, 2'b01, 1'b1, 1'b0, lat, per);
    chk(lat == 1, "R5 hw fast bypass A", lat, 1);
    chk(per == 6, "R2 type A period", per, 6);
    measure(1, 2'b10, 1'b1, 1'b0, lat, per);
    chk(per == 5, "R2 type B period", per, 5);
    measure(0, 2'b11, 1'b1, 1'b0, lat, per);
    chk(per == 3, "R2 type F period", per, 3);
    // R3 fallback when memory is not fast.
    measure(0, 2'b11, 1'b0, 1'b0, lat, per);
    chk(lat == 9, "R3 fallback latency", lat, 9);
    chk(per == 8, "R3 fallback period", per, 8);

    // R6 priority on simultaneous requests; I/O-to-memory strobes.
    dir = 4'hF;
    sw_req = 4'b1100;
    @(negedge clk);
    chk(dack_n == 4'b1011, "R6 lowest wins", dack_n, 11);
    chk(!ior_n && memr_n, "R7 dir 1 read strobe", {ior_n, memr_n}, 1);
    @(negedge clk);
    chk(!memw_n && iow_n, "R7 dir 1 write strobe", {memw_n, iow_n}, 1);
    // R8: ch0 requests while ch2 holds the grant.
    sw_req[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk(dack_n == 4'b1011, "R8 no preemption", dack_n, 11);
    sw_req[2] = 1'b0;
    sw_req[3] = 1'b0;
    for (n = 0; n < 20; n++) begin
      @(negedge clk);
      if (dack_n == 4'b1110) break;
    end
    chk(dack_n == 4'b1110, "R8 handover to ch0", dack_n, 14);
    idle_inputs();
    wait_idle();

    // R10: random traffic against the reference model.
    model_cmp = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) dreq[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) sw_req[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 11) == 0) tmode = 8'($urandom);
      if ($urandom_range(0, 11) == 0) fast_mem = 4'($urandom);
      if ($urandom_range(0, 11) == 0) dir = 4'($urandom);
    end
    @(negedge clk);
    model_cmp = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule